// File: doc/BRIEF.md
# RF Bias Burst Guard

This controller decides when the bias of an RF power stage is switched on. It takes an on/off command and a single-bit mismatch flag. The flag comes from an external comparator and is high when the reflected wave is too large compared with the forward wave, nominally at a 2:1 standing-wave ratio. Each time the command asks for RF, the guard enables bias at once and opens a fixed grace window of 200 µs. The mismatch flag is ignored for the whole window. On the window's last cycle the flag is read once. A clear reading lets bias follow the command from then on. A fault reading forces bias off for a fixed 2 ms lockout. The guard never reduces output level, so every burst runs at full peak power.

When the lockout ends and the command is still high, a new window opens by itself. A load that stays mismatched therefore sees short full-power bursts at roughly a 10% duty cycle, which is enough to strike a hard-to-start load without overheating the transistors. Both inputs pass through a two-flop synchronizer. Window and lockout lengths are derived from a clock-frequency parameter.

The control is a four-state machine. `ST_IDLE` has bias off. `ST_WINDOW` has bias on and the fault ignored. `ST_RUN` has bias on and follows the command. `ST_LOCK` has bias off and the status high. The transitions are named as follows:
- start: IDLE to WINDOW, taken when the command is high.
- abort: WINDOW to IDLE or RUN to IDLE, taken when the command drops.
- clear: WINDOW to RUN, taken when the window ends with no fault.
- trip: WINDOW to LOCK, taken when the window ends with a fault.
- retry: LOCK to WINDOW, taken when the lockout ends with the command high.
- rest: LOCK to IDLE, taken when the lockout ends with the command low.

Top module: `burst_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, bias enable and protection status are both low.
- R2: With the guard idle, a command going high raises bias enable on the third rising clock edge after the change, and that edge starts a grace window.
- R3: A fault pulse that starts and ends inside the grace window, and is low on the window's last cycle, causes no lockout: bias stays high once the window ends.
- R4: A fault that is high on the window's last cycle starts a lockout. During the lockout bias enable is low and protection status is high, and the lockout lasts exactly the lockout cycle count.
- R5: After a clear window, bias enable stays high for as long as the command stays high, and any later fault has no effect on it.
- R6: A command going low drops bias enable on the third rising edge after the change and cancels a running window. The next command high starts a full-length window.
- R7: A command going low during a lockout does not shorten it. Protection status stays high to the lockout's end, and then both outputs go low.
- R8: If the command is still high when a lockout ends, bias goes high on the very next cycle and a new window starts. A persistent fault therefore produces bursts of one window length separated by one lockout length.
- R9: The window lasts CLK_HZ x WINDOW_US / 10^6 cycles and the lockout lasts CLK_HZ x LOCK_US / 10^6 cycles. For example, with CLK_HZ = 100000 these are 20 and 200 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | RF on/off command; high requests RF, asynchronous to clk |
| mismatch_i | input | 1 | Mismatch fault flag; high means over threshold, asynchronous to clk |
| bias_en_o | output | 1 | Bias enable for the power stage |
| prot_o | output | 1 | High for the whole of a protection lockout |

## Verification
The assertions rely on both inputs being level signals that stay put for at least two clock cycles, so that the synchronized copies are clean. They also rely on the fault flag being steady around the window's last cycle, so the single reading is meaningful. The stimulus changes inputs only on falling clock edges and holds each level for many cycles. It places every fault change well clear of the sampling cycle, either mid-window or during a lockout. The bench runs with a reduced clock-frequency parameter, so that a lockout fits in a few hundred cycles.

// File: rtl/burst_guard_pkg.sv
package burst_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_RUN    = 2'd2,
        ST_LOCK   = 2'd3
    } guard_state_t;

    // cycles in a span of 'us' microseconds at 'hz' clock frequency
    function automatic int span_cycles(input int hz, input int us);
        return ((hz / 1000) * us) / 1000;
    endfunction

endpackage

// File: rtl/burst_guard_sync.sv
module burst_guard_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/burst_guard_timer.sv
module burst_guard_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= load_val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    // R9: a running span shortens by exactly one cycle per clock
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt == $past(cnt) - 1'b1));

    // R9: an idle timer stays at zero until reloaded
    p_zero_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/burst_guard.sv
module burst_guard
    import burst_guard_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int WINDOW_US = 200,
    parameter int LOCK_US   = 2000,
    parameter int SYNC_LEN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic mismatch_i,
    output logic bias_en_o,
    output logic prot_o
);

    localparam int WIN_CYC  = (span_cycles(CLK_HZ, WINDOW_US) < 1) ? 1 : span_cycles(CLK_HZ, WINDOW_US);
    localparam int LOCK_CYC = (span_cycles(CLK_HZ, LOCK_US) < 1) ? 1 : span_cycles(CLK_HZ, LOCK_US);
    localparam int MAX_CYC  = (LOCK_CYC > WIN_CYC) ? LOCK_CYC : WIN_CYC;
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] WIN_LOAD  = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYC - 1);

    logic [1:0]       sync_q;
    logic             cmd_s;
    logic             flt_s;
    guard_state_t     state;
    guard_state_t     state_nx;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    burst_guard_sync #(.W(2), .STAGES(SYNC_LEN)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mismatch_i, cmd_i}),
        .q_o   (sync_q)
    );

    assign cmd_s = sync_q[0];
    assign flt_s = sync_q[1];

    burst_guard_timer #(.W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions and timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = WIN_LOAD;
        unique case (state)
            ST_IDLE: begin
                if (cmd_s) begin                 // start
                    state_nx = ST_WINDOW;
                    tmr_load = 1'b1;
                end
            end
            ST_WINDOW: begin
                if (!cmd_s) begin                // abort
                    state_nx = ST_IDLE;
                end else if (tmr_zero) begin
                    if (flt_s) begin             // trip
                        state_nx = ST_LOCK;
                        tmr_load = 1'b1;
                        tmr_val  = LOCK_LOAD;
                    end else begin               // clear
                        state_nx = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!cmd_s) state_nx = ST_IDLE;  // abort
            end
            ST_LOCK: begin
                if (tmr_zero) begin
                    if (cmd_s) begin             // retry
                        state_nx = ST_WINDOW;
                        tmr_load = 1'b1;
                    end else begin               // rest
                        state_nx = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        bias_en_o = 1'b0;
        prot_o    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_WINDOW: bias_en_o = 1'b1;
            ST_RUN:    bias_en_o = 1'b1;
            ST_LOCK:   prot_o    = 1'b1;
        endcase
    end

    // R4: lockout and bias never overlap
    p_lock_forces_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_o |-> !bias_en_o);

    // R4: fault read at the window's end starts a lockout
    p_fault_at_end_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && tmr_zero && cmd_s && flt_s) |=> (prot_o && !bias_en_o));

    // R3: clear reading at the window's end keeps bias on
    p_clear_end_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && tmr_zero && cmd_s && !flt_s) |=> (bias_en_o && !prot_o));

    // R3: no lockout while the window is still counting
    p_window_ignores_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && !tmr_zero) |=> !prot_o);

    // R5: steady command after a clear window keeps bias on
    p_run_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cmd_s) |=> bias_en_o);

    // R6: a low command outside lockout drops bias
    p_cmd_low_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_s && state != ST_LOCK) |=> !bias_en_o);

    // R7: an unfinished lockout continues whatever the command does
    p_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !tmr_zero) |=> prot_o);

    // R8: lockout end with command high retries immediately
    p_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && tmr_zero && cmd_s) |=> (bias_en_o && !prot_o));

endmodule

// File: tb/test_burst_guard.sv
module test_burst_guard;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd = 1'b0;
    logic flt = 1'b0;
    logic bias_en;
    logic prot;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    typedef struct {
        int    at;
        logic  bias;
        logic  prot;
        string req;
    } exp_t;

    exp_t sb[$];

    // 100 kHz nominal: window 20 cycles, lockout 200 cycles (R9)
    burst_guard #(.CLK_HZ(100_000), .WINDOW_US(200), .LOCK_US(2000)) i_burst_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .mismatch_i (flt),
        .bias_en_o  (bias_en),
        .prot_o     (prot)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic at(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_out(input int n, input logic b, input logic p, input string req);
        exp_t e;
        e.at = n; e.bias = b; e.prot = p; e.req = req;
        sb.push_back(e);
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    // monitor: pop expectations as their cycle arrives
    always @(negedge clk) begin
        while (!done && sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (e.at < cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed (now %0d), expected bias=%0b prot=%0b",
                         e.req, e.at, cyc, e.bias, e.prot);
            end else if (bias_en !== e.bias || prot !== e.prot) begin
                n_fail++;
                $display("FAIL %s: cycle %0d bias=%0b prot=%0b, expected bias=%0b prot=%0b",
                         e.req, cyc, bias_en, prot, e.bias, e.prot);
            end
        end
    end

    // driver
    initial begin
        expect_out(3, 1'b0, 1'b0, "R1");
        at(5);  rst_n = 1'b1;
        expect_out(6, 1'b0, 1'b0, "R1");

        // start, fault pulse inside window only, then run
        at(10); cmd = 1'b1;
        expect_out(12, 1'b0, 1'b0, "R2");
        expect_out(13, 1'b1, 1'b0, "R2");
        at(16); flt = 1'b1;
        at(22); flt = 1'b0;
        expect_out(33, 1'b1, 1'b0, "R3");
        expect_out(40, 1'b1, 1'b0, "R3");
        at(45); flt = 1'b1;
        expect_out(60, 1'b1, 1'b0, "R5");
        at(65); flt = 1'b0;
        at(70); cmd = 1'b0;
        expect_out(72, 1'b1, 1'b0, "R6");
        expect_out(73, 1'b0, 1'b0, "R6");

        // window cancelled before its end; fault never read
        at(90); cmd = 1'b1;
        at(95); flt = 1'b1;
        at(100); cmd = 1'b0;
        expect_out(110, 1'b0, 1'b0, "R6");

        // persistent fault: trip, lockout, retry bursts
        at(120); cmd = 1'b1;
        expect_out(142, 1'b1, 1'b0, "R9");
        expect_out(143, 1'b0, 1'b1, "R4");
        expect_out(342, 1'b0, 1'b1, "R4");
        expect_out(343, 1'b1, 1'b0, "R8");
        expect_out(362, 1'b1, 1'b0, "R8");
        expect_out(363, 1'b0, 1'b1, "R8");
        expect_out(563, 1'b1, 1'b0, "R8");
        at(570); flt = 1'b0;
        expect_out(583, 1'b1, 1'b0, "R5");
        expect_out(600, 1'b1, 1'b0, "R5");
        at(610); cmd = 1'b0;
        expect_out(613, 1'b0, 1'b0, "R6");

        // command dropped during lockout
        at(620); flt = 1'b1;
        at(630); cmd = 1'b1;
        expect_out(633, 1'b1, 1'b0, "R2");
        at(700); cmd = 1'b0;
        expect_out(800, 1'b0, 1'b1, "R7");
        expect_out(852, 1'b0, 1'b1, "R7");
        expect_out(853, 1'b0, 1'b0, "R7");
        at(870); flt = 1'b0;

        at(900);
        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end by cycle 900", cyc);
            summary();
            $finish;
        end
    end

endmodule